// File: doc/BRIEF.md
# Clock-Settling Watchdog Timer

An 8-bit up-counting watchdog that serves two purposes. In its normal role, once software sets the enable bit, each overflow of the counter either raises a reset pulse or sets an interval flag that drives an interrupt. The counter advances on ticks from a prescaler, and a 3-bit select field chooses the prescaler ratio.

The same counter also times the wait for an oscillator or PLL to settle. A rising edge on the non-maskable interrupt input while the system is in standby starts a settling run. A strobe that marks a write to the frequency control register does the same. A settling run counts even when the enable bit is clear. Its overflow sends a single-cycle resume pulse to the clock generator, sets no flag and raises no reset. The counter then parks at 0x00 so software can confirm that the run has ended. Software chooses the settling delay by loading a start value before the event. A wake caused by the reset pin does not involve this block.

Every register write must carry a fixed key in the upper byte of the write data, so stray writes cannot disturb the timer.

Top module: `settle_wdt`

## Requirements
- R1: After reset, the control, counter and status registers read 0x00, and `wdt_rst_o`, `wdt_irq_o` and `clk_resume_o` are low.
- R2: A write to address 0 (control), 1 (counter) or 2 (status) takes effect only when `bus_wdata_i[15:8]` equals 0x5A. Any other upper byte leaves the register unchanged.
- R3: Control register layout: bit 7 is enable, bit 6 is mode (1 = reset, 0 = interval), and bits 2:0 are the clock select. Select values 0 to 7 give a tick every 1, 4, 16, 32, 64, 256, 1024 or 4096 cycles. A tick falls on the edge at which n mod ratio equals ratio−1, where n counts edges since reset release. On each tick while counting, the counter increments by one. Address 3 reads 0x00.
- R4: In interval mode with enable set and no settling run active, a counter step from 0xFF to 0x00 sets status bit 6. `wdt_irq_o` is high while that bit is set.
- R5: In reset mode with enable set and no settling run active, a step from 0xFF to 0x00 sets status bit 7. `wdt_rst_o` is then high for exactly 16 cycles, starting the cycle after the step.
- R6: A keyed write to status clears each flag whose data bit (7 or 6) is 0 and keeps each flag whose data bit is 1. A flag set by an overflow in the same cycle stays set.
- R7: A one-cycle `frq_wr_i` strobe starts a settling run whatever the enable bit is. The counter begins counting on the next tick after the strobe edge.
- R8: A rising edge on `nmi_i` while `standby_i` is high starts a settling run. An edge while `standby_i` is low is ignored.
- R9: When a settling run overflows, `clk_resume_o` is high for one cycle, the counter reads 0x00, both flags stay clear and `wdt_rst_o` stays low. The run then ends, and with enable clear the counter holds its value until it is written.
- R10: A keyed counter write in the same cycle as a tick loads the written value, and that cycle causes no increment and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 control, 1 counter, 2 status) |
| bus_wdata_i | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| standby_i | input | 1 | System is in standby with clocks stopped |
| nmi_i | input | 1 | Non-maskable interrupt request line |
| frq_wr_i | input | 1 | One-cycle strobe for a frequency control register write |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| wdt_irq_o | output | 1 | Interval timer interrupt |
| clk_resume_o | output | 1 | One-cycle request to restart the system clock |

## Verification
Register writes, the status flags, the reset pulse, the interrupt and the resume pulse all appear one edge after the cycle that causes them. A trigger seen at one edge lets counting start at the next edge. The bench models each edge behaviourally and compares all outputs, and the register selected by the current address, 5 ns after every rising edge. It changes inputs only on falling edges, so every comparison sees exactly one edge's worth of change. The directed checks read registers on the falling edge that follows the write edge. Settling runs are awaited with bounded polls on `clk_resume_o`, so a late or missing resume pulse is reported rather than waited out.

// File: rtl/settle_wdt_pkg.sv
package settle_wdt_pkg;
  localparam logic [7:0] WR_KEY = 8'h5A;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       en;
    logic       rst_mode;
    logic [2:0] cks;
  } ctrl_t;

  function automatic logic [3:0] cks_shift(input logic [2:0] cks);
    case (cks)
      3'd0:    return 4'd0;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd5;
      3'd4:    return 4'd6;
      3'd5:    return 4'd8;
      3'd6:    return 4'd10;
      default: return 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/settle_wdt_prescaler.sv
module settle_wdt_prescaler
  import settle_wdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cks_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // low bits selected by the ratio all ones -> tick
  always_comb begin
    mask   = ~({PRE_W{1'b1}} << cks_shift(cks_i));
    tick_o = &(pre_q | ~mask);
  end
endmodule

// File: rtl/settle_wdt_regs.sv
module settle_wdt_regs
  import settle_wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [15:0]      wdata_i,
  input  logic             wovf_set_i,
  input  logic             iovf_set_i,
  output ctrl_t            ctrl_o,
  output logic             wovf_o,
  output logic             iovf_o,
  output logic             cnt_we_o,
  output logic [CNT_W-1:0] cnt_wdata_o
);
  logic key_ok, wr_ctrl, wr_stat;

  assign key_ok      = (wdata_i[15:8] == WR_KEY);
  assign wr_ctrl     = we_i && key_ok && (reg_addr_e'(addr_i) == ADDR_CTRL);
  assign wr_stat     = we_i && key_ok && (reg_addr_e'(addr_i) == ADDR_STAT);
  assign cnt_we_o    = we_i && key_ok && (reg_addr_e'(addr_i) == ADDR_CNT);
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (wr_ctrl) begin
      ctrl_o.en       <= wdata_i[7];
      ctrl_o.rst_mode <= wdata_i[6];
      ctrl_o.cks      <= wdata_i[2:0];
    end
  end

  // write-0-to-clear; a set in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wovf_o <= 1'b0;
      iovf_o <= 1'b0;
    end else begin
      wovf_o <= wovf_set_i | (wovf_o & ~(wr_stat & ~wdata_i[7]));
      iovf_o <= iovf_set_i | (iovf_o & ~(wr_stat & ~wdata_i[6]));
    end
  end
endmodule

// File: rtl/settle_wdt_core.sv
module settle_wdt_core #(
  parameter int CNT_W      = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             rst_mode_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             standby_i,
  input  logic             nmi_i,
  input  logic             frq_wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wovf_set_o,
  output logic             iovf_set_o,
  output logic             wdt_rst_o,
  output logic             clk_resume_o
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic             settle_q, nmi_q;
  logic [RST_W-1:0] rst_left_q;
  logic             run, step, wrap, ovf_settle, ovf_norm, trig;

  assign run        = en_i | settle_q;
  assign step       = run & tick_i & ~cnt_we_i;
  assign wrap       = step & (&cnt_o);
  assign ovf_settle = wrap & settle_q;
  assign ovf_norm   = wrap & ~settle_q;
  assign wovf_set_o = ovf_norm & rst_mode_i;
  assign iovf_set_o = ovf_norm & ~rst_mode_i;
  assign trig       = frq_wr_i | (standby_i & nmi_i & ~nmi_q);
  assign wdt_rst_o  = (rst_left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o        <= '0;
      settle_q     <= 1'b0;
      nmi_q        <= 1'b0;
      clk_resume_o <= 1'b0;
      rst_left_q   <= '0;
    end else begin
      nmi_q        <= nmi_i;
      clk_resume_o <= ovf_settle;
      if (cnt_we_i)  cnt_o <= cnt_wdata_i;
      else if (step) cnt_o <= cnt_o + 1'b1;
      if (trig)            settle_q <= 1'b1;
      else if (ovf_settle) settle_q <= 1'b0;
      if (wovf_set_o)           rst_left_q <= RST_W'(RST_CYCLES);
      else if (rst_left_q != 0) rst_left_q <= rst_left_q - 1'b1;
    end
  end
endmodule

// File: rtl/settle_wdt.sv
module settle_wdt
  import settle_wdt_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 12,
  parameter int RST_CYCLES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  input  logic        standby_i,
  input  logic        nmi_i,
  input  logic        frq_wr_i,
  output logic        wdt_rst_o,
  output logic        wdt_irq_o,
  output logic        clk_resume_o
);
  ctrl_t            ctrl_w;
  logic             wovf_w, iovf_w, wovf_set, iovf_set, tick, cnt_we;
  logic [CNT_W-1:0] cnt_wdata, cnt_w;

  settle_wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .cks_i(ctrl_w.cks), .tick_o(tick)
  );

  settle_wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .wovf_set_i(wovf_set), .iovf_set_i(iovf_set),
    .ctrl_o(ctrl_w), .wovf_o(wovf_w), .iovf_o(iovf_w),
    .cnt_we_o(cnt_we), .cnt_wdata_o(cnt_wdata)
  );

  settle_wdt_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk_i, .rst_ni, .tick_i(tick),
    .en_i(ctrl_w.en), .rst_mode_i(ctrl_w.rst_mode),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .standby_i, .nmi_i, .frq_wr_i,
    .cnt_o(cnt_w), .wovf_set_o(wovf_set), .iovf_set_o(iovf_set),
    .wdt_rst_o, .clk_resume_o
  );

  assign wdt_irq_o = iovf_w;

  always_comb begin
    case (reg_addr_e'(bus_addr_i))
      ADDR_CTRL: bus_rdata_o = {ctrl_w.en, ctrl_w.rst_mode, 3'b000, ctrl_w.cks};
      ADDR_CNT:  bus_rdata_o = 8'(cnt_w);
      ADDR_STAT: bus_rdata_o = {wovf_w, iovf_w, 6'b0};
      default:   bus_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/settle_wdt_sva.sv
module settle_wdt_sva #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic [15:0]      bus_wdata_i,
  input logic [4:0]       ctrl_bits,
  input logic [CNT_W-1:0] cnt,
  input logic             wovf,
  input logic             iovf,
  input logic             wdt_rst_o,
  input logic             wdt_irq_o,
  input logic             clk_resume_o
);
  a_r2_ctrl_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == 2'd0 && bus_wdata_i[15:8] == 8'h5A) |=> $stable(ctrl_bits));

  a_r4_irq_from_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_irq_o) |-> $past(cnt) == {CNT_W{1'b1}});

  a_r5_rst_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> wovf && $past(cnt) == {CNT_W{1'b1}});

  a_r9_resume_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_resume_o |=> !clk_resume_o);

  a_r9_resume_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_resume_o |-> cnt == '0);

  a_r9_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_resume_o |-> !$rose(wovf) && !$rose(iovf) && !$rose(wdt_rst_o));
endmodule

bind settle_wdt settle_wdt_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .ctrl_bits(ctrl_w), .cnt(cnt_w), .wovf(wovf_w), .iovf(iovf_w),
  .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o), .clk_resume_o(clk_resume_o)
);

// File: tb/tb_settle_wdt.sv
`timescale 1ns/1ps
module tb_settle_wdt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, standby = 1'b0, nmi = 1'b0, frq = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [7:0] rdata;
  logic rst_o, irq_o, resume_o;

  always #10 clk = ~clk;

  settle_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .standby_i(standby),
    .nmi_i(nmi), .frq_wr_i(frq), .wdt_rst_o(rst_o), .wdt_irq_o(irq_o),
    .clk_resume_o(resume_o)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_en, m_mode, m_settle, m_nmi_q, m_wovf, m_iovf, m_resume;
  bit [2:0] m_cks;
  int m_cnt, m_rst_left, cyc;

  function automatic int ratio(input bit [2:0] s);
    int tbl[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
    return tbl[s];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_cks = 0; m_settle = 0; m_nmi_q = 0;
      m_wovf = 0; m_iovf = 0; m_resume = 0; m_cnt = 0; m_rst_left = 0; cyc = 0;
    end else begin
      int div;
      bit tick, key, cw, step, wrap, os, on, trig;
      div  = ratio(m_cks);
      tick = (cyc % div) == div - 1;
      cyc++;
      key  = (wdata[15:8] == 8'h5A) && we;
      cw   = key && addr == 2'd1;
      step = (m_en || m_settle) && tick && !cw;
      wrap = step && m_cnt == 255;
      os   = wrap && m_settle;
      on   = wrap && !m_settle;
      trig = frq || (standby && nmi && !m_nmi_q);
      m_resume = os;
      if (m_rst_left > 0) m_rst_left--;
      if (on && m_mode) m_rst_left = 16;
      if (key && addr == 2'd2 && !wdata[7]) m_wovf = 0;
      if (key && addr == 2'd2 && !wdata[6]) m_iovf = 0;
      if (on && m_mode)  m_wovf = 1;
      if (on && !m_mode) m_iovf = 1;
      if (cw) m_cnt = wdata[7:0];
      else if (step) m_cnt = (m_cnt + 1) % 256;
      if (trig) m_settle = 1;
      else if (os) m_settle = 0;
      if (key && addr == 2'd0) begin
        m_en = wdata[7]; m_mode = wdata[6]; m_cks = wdata[2:0];
      end
      m_nmi_q = nmi;
    end
  end

  // per-cycle comparison, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      int exp_rd;
      string tag;
      case (addr)
        2'd0: begin exp_rd = {m_en, m_mode, 3'b000, m_cks}; tag = "R3 ctrl"; end
        2'd1: begin exp_rd = m_cnt; tag = "R3 count"; end
        2'd2: begin exp_rd = {m_wovf, m_iovf, 6'b0}; tag = "R6 status"; end
        default: begin exp_rd = 0; tag = "R3 unused"; end
      endcase
      check(rdata == exp_rd[7:0], tag, rdata, exp_rd);
      check(rst_o == (m_rst_left > 0), "R5 rst", rst_o, m_rst_left > 0);
      check(irq_o == m_iovf, "R4 irq", irq_o, m_iovf);
      check(resume_o == m_resume, "R9 resume", resume_o, m_resume);
    end
  end

  task automatic bus_wr(input bit [1:0] a, input bit [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 16'h0;
    #1;
  endtask

  task automatic rd_check(input bit [1:0] a, input int exp, input string req);
    addr = a; #1;
    check(rdata == exp[7:0], req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_resume(input int max, output bit seen);
    seen = 0;
    for (int i = 0; i < max && !seen; i++) begin
      @(negedge clk);
      if (resume_o) seen = 1;
    end
    #1;
  endtask

  task automatic run_tests;
    bit seen;
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    rd_check(2'd0, 0, "R1 ctrl");
    rd_check(2'd1, 0, "R1 count");
    rd_check(2'd2, 0, "R1 status");
    check(!rst_o && !irq_o && !resume_o, "R1 outputs", {rst_o, irq_o, resume_o}, 0);
    // R2 unkeyed writes ignored
    bus_wr(2'd0, 16'h00C0);
    rd_check(2'd0, 0, "R2 ctrl");
    bus_wr(2'd1, 16'h1234);
    rd_check(2'd1, 0, "R2 count");
    // R4 interval overflow
    bus_wr(2'd1, 16'h5AF0);
    bus_wr(2'd0, 16'h5A80);
    idle(30);
    check(irq_o == 1, "R4 irq", irq_o, 1);
    rd_check(2'd2, 8'h40, "R4 status");
    // R6 keep-on-1 then clear
    bus_wr(2'd2, 16'h5A40);
    rd_check(2'd2, 8'h40, "R6 keep");
    bus_wr(2'd2, 16'h5A00);
    rd_check(2'd2, 8'h00, "R6 clear");
    // R10 write wins over increment (ratio 1 ticks every cycle)
    bus_wr(2'd1, 16'h5A10);
    rd_check(2'd1, 8'h10, "R10 load");
    // R5 reset mode, ratio 4
    bus_wr(2'd0, 16'h5AC1);
    bus_wr(2'd1, 16'h5AF8);
    highs = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (rst_o) highs++;
    end
    #1;
    check(highs == 16, "R5 pulse length", highs, 16);
    rd_check(2'd2, 8'h80, "R5 status");
    bus_wr(2'd0, 16'h5A02);
    bus_wr(2'd2, 16'h5A00);
    // R7 frequency strobe with enable clear, ratio 16
    bus_wr(2'd1, 16'h5AF0);
    idle(40);
    rd_check(2'd1, 8'hF0, "R7 idle hold");
    @(negedge clk); frq = 1;
    @(negedge clk); frq = 0;
    wait_resume(16 * 16 + 40, seen);
    check(seen, "R7 settle run", seen, 1);
    idle(50);
    rd_check(2'd1, 0, "R9 parked");
    rd_check(2'd2, 0, "R9 no flags");
    // R8 NMI without standby ignored, ratio 4096
    bus_wr(2'd0, 16'h5A07);
    bus_wr(2'd1, 16'h5AFE);
    @(negedge clk); nmi = 1;
    idle(5);
    nmi = 0;
    idle(9000);
    rd_check(2'd1, 8'hFE, "R8 ignored");
    @(negedge clk); standby = 1;
    @(negedge clk); nmi = 1;
    wait_resume(10000, seen);
    check(seen, "R8 standby wake", seen, 1);
    standby = 0; nmi = 0;
    idle(100);
    rd_check(2'd1, 0, "R9 hold zero");
    bus_wr(2'd1, 16'h5A33);
    idle(50);
    rd_check(2'd1, 8'h33, "R9 no count after run");
    rd_check(2'd3, 0, "R3 unused addr");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule